// File: doc/BRIEF.md
# Wake Event Status Controller

This block gathers wake-up events from a set of asynchronous board-level lines and turns them into one active-low, open-drain wake request. It watches two ring-indicator lines, a ring line, the keyboard and mouse data lines and a bank of general-purpose inputs. Each line is brought into the system clock domain by a two-flop synchronizer. An edge detector then catches the line's active transition and latches it into a per-source status bit.

The wake request is modelled as an output enable that pulls the shared line low. The block never drives the line high. A source pulls the line only when its status bit is set, its matching enable bit is set and the global enable is on. A second path carries an aggregated system-management event, which is a level already in the system clock domain. That path reaches the wake request only when the global enable is on and two separate gating bits are also set.

Software reaches the block through a two-bit register index with a write strobe and write data, and reads back through a combinational read port. Status bits are write-one-to-clear. Enable and control bits are plain read/write.

Top module: `wake_event_ctrl`

## Requirements
- R1: After the synchronous active-high reset, every register reads zero and `wake_oe` is 0.
- R2: An active transition on a source sets its status bit, even when the enables are clear. The status bit sits at the same position as its enable bit: bit 0 is ring A, bit 1 ring B, bit 2 the ring line, bit 3 keyboard data, bit 4 mouse data, and bit 5+i general input i. The same transition also sets the summary bit (control bit 15). The status register is at index 0 and the enable register at index 1.
- R3: The active edge is falling for bits 0 to 4. For general input i it is rising when `GP_RISE[i]` is 1 and falling otherwise. A transition in the other direction changes no status bit.
- R4: Writing 1 to a status bit, or to summary bit 15 at index 2, clears that bit. Writing 0 leaves it unchanged.
- R5: When a hardware set and a write-one clear reach the same status bit in the same cycle, the bit ends up set.
- R6: With the global enable on, `wake_oe` is 1 one cycle after any status bit and its enable bit are both set. This includes the case where software sets the enable after the event has been latched.
- R7: With the global enable (control bit 0, index 2) clear, `wake_oe` stays 0.
- R8: The `mgmt_evt` input raises `wake_oe` only when the global enable, the device-interrupt enable (control bit 1) and the management-to-wake enable (control bit 2) are all set.
- R9: The enable register and control bits 0 to 2 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high standby-power reset |
| ring_ind_a_n | input | 1 | Ring indicator A, asynchronous, active on its falling edge |
| ring_ind_b_n | input | 1 | Ring indicator B, asynchronous, active on its falling edge |
| ring_line_n | input | 1 | Ring line, asynchronous, active on its falling edge |
| kbd_data | input | 1 | Keyboard data line, asynchronous, active on its falling edge |
| mouse_data | input | 1 | Mouse data line, asynchronous, active on its falling edge |
| gp_in | input | NUM_GP | General-purpose wake inputs, asynchronous, with the edge chosen by GP_RISE |
| mgmt_evt | input | 1 | Aggregated system-management event level, synchronous to clk |
| reg_idx | input | 2 | Register index: 0 status, 1 enable, 2 control |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for the register selected by reg_idx |
| wake_oe | output | 1 | Pull-low enable for the open-drain wake line |

## Verification
The bench builds the block with eight general inputs and `GP_RISE` = 8'h0F, so inputs 0 to 3 wake on rising edges and inputs 4 to 7 on falling edges. Both edge polarities are therefore covered in one build, next to the fixed falling-edge sources. This setup lets the bench clear a status bit while a line is held at its active level, then release the line and show that the inactive edge is ignored for both polarities. Since status, enable and control all fit in sixteen bits, every bit position can be written and read back through the register port.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int FIXED_SRC = 5;
    localparam int REG_W     = 16;

    localparam int CTRL_GLOBAL  = 0;
    localparam int CTRL_DEVINT  = 1;
    localparam int CTRL_MGMT    = 2;
    localparam int CTRL_SUMMARY = 15;

    typedef enum logic [1:0] {
        IDX_STATUS = 2'd0,
        IDX_ENABLE = 2'd1,
        IDX_CTRL   = 2'd2,
        IDX_RSVD   = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic global_en;
        logic devint_en;
        logic mgmt_wake_en;
    } ctrl_t;

    typedef struct packed {
        logic wr_status;
        logic wr_enable;
        logic wr_ctrl;
    } wr_dec_t;

    function automatic ctrl_t ctrl_from_word(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.global_en    = w[CTRL_GLOBAL];
        c.devint_en    = w[CTRL_DEVINT];
        c.mgmt_wake_en = w[CTRL_MGMT];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c, input logic summary);
        logic [REG_W-1:0] w;
        w               = '0;
        w[CTRL_GLOBAL]  = c.global_en;
        w[CTRL_DEVINT]  = c.devint_en;
        w[CTRL_MGMT]    = c.mgmt_wake_en;
        w[CTRL_SUMMARY] = summary;
        return w;
    endfunction

endpackage

// File: rtl/wake_edge_cap.sv
module wake_edge_cap #(
    parameter int              NUM_SRC   = 13,
    parameter logic [NUM_SRC-1:0] RISE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] raw_in,
    output logic [NUM_SRC-1:0] edge_evt
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam logic IDLE = ~RISE_MASK[i];
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= IDLE;
                sync_q <= IDLE;
                prev_q <= IDLE;
            end else begin
                meta_q <= raw_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        if (RISE_MASK[i]) begin : g_rise
            assign edge_evt[i] = sync_q & ~prev_q;
        end else begin : g_fall
            assign edge_evt[i] = ~sync_q & prev_q;
        end

        AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            edge_evt[i] |=> !edge_evt[i]); // R2
    end

endmodule

// File: rtl/wake_regs.sv
module wake_regs
    import wake_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         reg_idx,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic [NUM_SRC-1:0] set_evt,
    output logic [NUM_SRC-1:0] sts_q,
    output logic [NUM_SRC-1:0] en_q,
    output ctrl_t              ctrl_q,
    output logic               summary_q,
    output logic [REG_W-1:0]   reg_rdata
);

    wr_dec_t            dec;
    logic [NUM_SRC-1:0] clr_mask;
    logic               sum_clr;

    always_comb begin
        dec = '0;
        if (reg_wr) begin
            case (reg_idx_e'(reg_idx))
                IDX_STATUS: dec.wr_status = 1'b1;
                IDX_ENABLE: dec.wr_enable = 1'b1;
                IDX_CTRL:   dec.wr_ctrl   = 1'b1;
                default:    ;
            endcase
        end
    end

    assign clr_mask = dec.wr_status ? reg_wdata[NUM_SRC-1:0] : '0;
    assign sum_clr  = dec.wr_ctrl & reg_wdata[CTRL_SUMMARY];

    // status bits: hardware set dominates a software clear
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst)             sts_q[i] <= 1'b0;
            else if (set_evt[i]) sts_q[i] <= 1'b1;
            else if (clr_mask[i]) sts_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            summary_q <= 1'b0;
            en_q      <= '0;
            ctrl_q    <= '0;
        end else begin
            if (|set_evt)      summary_q <= 1'b1;
            else if (sum_clr)  summary_q <= 1'b0;
            if (dec.wr_enable) en_q      <= reg_wdata[NUM_SRC-1:0];
            if (dec.wr_ctrl)   ctrl_q    <= ctrl_from_word(reg_wdata);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx_e'(reg_idx))
            IDX_STATUS: reg_rdata[NUM_SRC-1:0] = sts_q;
            IDX_ENABLE: reg_rdata[NUM_SRC-1:0] = en_q;
            IDX_CTRL:   reg_rdata = ctrl_to_word(ctrl_q, summary_q);
            default:    reg_rdata = '0;
        endcase
    end

    AST_STS_ONLY_EVENT: assert property (@(posedge clk) disable iff (rst)
        ((sts_q & ~$past(sts_q) & ~$past(set_evt)) == '0)); // R2
    AST_W1C_EXACT: assert property (@(posedge clk) disable iff (rst)
        (dec.wr_status && set_evt == '0) |=> (sts_q == ($past(sts_q) & ~$past(reg_wdata[NUM_SRC-1:0])))); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (set_evt != '0) |=> ((sts_q & $past(set_evt)) == $past(set_evt))); // R5
    AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (rst)
        (set_evt != '0) |=> summary_q); // R2

endmodule

// File: rtl/wake_out_gen.sv
module wake_out_gen
    import wake_pkg::*;
#(
    parameter int NUM_SRC = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] sts_q,
    input  logic [NUM_SRC-1:0] en_q,
    input  ctrl_t              ctrl_q,
    input  logic               mgmt_evt,
    output logic               wake_oe
);

    logic src_hit;
    logic mgmt_hit;

    assign src_hit  = |(sts_q & en_q);
    assign mgmt_hit = mgmt_evt & ctrl_q.devint_en & ctrl_q.mgmt_wake_en;

    always_ff @(posedge clk) begin
        if (rst) wake_oe <= 1'b0;
        else     wake_oe <= ctrl_q.global_en & (src_hit | mgmt_hit);
    end

    AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.global_en |=> !wake_oe); // R7
    AST_OUT_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.global_en && (sts_q & en_q) != '0) |=> wake_oe); // R6
    AST_MGMT_BOTH: assert property (@(posedge clk) disable iff (rst)
        (wake_oe && !$past((sts_q & en_q) != '0)) |->
        $past(mgmt_evt && ctrl_q.devint_en && ctrl_q.mgmt_wake_en)); // R8

endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
    import wake_pkg::*;
#(
    parameter int                NUM_GP  = 8,
    parameter logic [NUM_GP-1:0] GP_RISE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ring_ind_a_n,
    input  logic              ring_ind_b_n,
    input  logic              ring_line_n,
    input  logic              kbd_data,
    input  logic              mouse_data,
    input  logic [NUM_GP-1:0] gp_in,
    input  logic              mgmt_evt,
    input  logic [1:0]        reg_idx,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              wake_oe
);

    localparam int                 NUM_SRC   = FIXED_SRC + NUM_GP;
    localparam logic [NUM_SRC-1:0] RISE_MASK = {GP_RISE, {FIXED_SRC{1'b0}}};

    if (NUM_SRC > REG_W) begin : g_size_check
        $error("wake_event_ctrl: too many sources for the register width");
    end

    logic [NUM_SRC-1:0] raw_src;
    logic [NUM_SRC-1:0] edge_evt;
    logic [NUM_SRC-1:0] sts_q;
    logic [NUM_SRC-1:0] en_q;
    ctrl_t              ctrl_q;
    logic               summary_q;

    assign raw_src = {gp_in, mouse_data, kbd_data, ring_line_n, ring_ind_b_n, ring_ind_a_n};

    wake_edge_cap #(
        .NUM_SRC   (NUM_SRC),
        .RISE_MASK (RISE_MASK)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (raw_src),
        .edge_evt (edge_evt)
    );

    wake_regs #(
        .NUM_SRC (NUM_SRC)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_idx   (reg_idx),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .set_evt   (edge_evt),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .ctrl_q    (ctrl_q),
        .summary_q (summary_q),
        .reg_rdata (reg_rdata)
    );

    wake_out_gen #(
        .NUM_SRC (NUM_SRC)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .sts_q    (sts_q),
        .en_q     (en_q),
        .ctrl_q   (ctrl_q),
        .mgmt_evt (mgmt_evt),
        .wake_oe  (wake_oe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wake_oe && !summary_q && sts_q == '0)); // R1

endmodule

// File: tb/wake_event_ctrl_tb.sv
`timescale 1ns/1ps
module wake_event_ctrl_tb;

    localparam int         NUM_GP  = 8;
    localparam logic [7:0] GP_RISE = 8'h0F;
    localparam int         NS      = 5 + NUM_GP;

    logic          clk = 1'b0;
    logic          rst;
    logic [NS-1:0] src_lvl;
    logic          mgmt;
    logic [1:0]    idx;
    logic          wr;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic          oe;

    int n_chk = 0;
    int n_err = 0;

    logic [NS-1:0] m_sts, m_en;
    logic          m_ge, m_di, m_mw, m_sum;

    always #2 clk = ~clk;

    wake_event_ctrl #(.NUM_GP(NUM_GP), .GP_RISE(GP_RISE)) u_dut (
        .clk(clk), .rst(rst),
        .ring_ind_a_n(src_lvl[0]), .ring_ind_b_n(src_lvl[1]), .ring_line_n(src_lvl[2]),
        .kbd_data(src_lvl[3]), .mouse_data(src_lvl[4]), .gp_in(src_lvl[NS-1:5]),
        .mgmt_evt(mgmt), .reg_idx(idx), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rdata(rdata), .wake_oe(oe)
    );

    function automatic logic idle_lvl(input int k);
        if (k >= 5) return ~GP_RISE[k-5];
        return 1'b1;
    endfunction

    function automatic logic exp_oe();
        return m_ge && ((|(m_sts & m_en)) || (mgmt && m_di && m_mw));
    endfunction

    function automatic logic [15:0] exp_reg(input logic [1:0] i);
        logic [15:0] w;
        w = '0;
        case (i)
            2'd0: w[NS-1:0] = m_sts;
            2'd1: w[NS-1:0] = m_en;
            2'd2: w = {m_sum, 12'd0, m_mw, m_di, m_ge};
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_check(input logic [1:0] i, input string req);
        @(negedge clk);
        idx = i;
        #1;
        check(req, rdata, exp_reg(i));
    endtask

    task automatic oe_check(input string req);
        check(req, {15'd0, oe}, {15'd0, exp_oe()});
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] i, input logic [15:0] d);
        @(negedge clk);
        idx = i; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        case (i)
            2'd0: m_sts = m_sts & ~d[NS-1:0];
            2'd1: m_en  = d[NS-1:0];
            2'd2: begin
                m_ge = d[0]; m_di = d[1]; m_mw = d[2];
                if (d[15]) m_sum = 1'b0;
            end
            default: ;
        endcase
        settle();
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        src_lvl[k] = ~idle_lvl(k);
        repeat (4) @(negedge clk);
        src_lvl[k] = idle_lvl(k);
        m_sts[k] = 1'b1;
        m_sum = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // clear a source while its line is held active, then release: the inactive edge must not set it
    task automatic inactive_edge(input int k);
        logic [15:0] d;
        @(negedge clk);
        src_lvl[k] = ~idle_lvl(k);
        repeat (4) @(negedge clk);
        m_sts[k] = 1'b1; m_sum = 1'b1;
        d = '0; d[k] = 1'b1;
        reg_write(2'd0, d);
        reg_write(2'd2, {1'b1, 12'd0, m_mw, m_di, m_ge});
        @(negedge clk);
        src_lvl[k] = idle_lvl(k);
        repeat (5) @(negedge clk);
        rd_check(2'd0, "R3 inactive edge status");
        rd_check(2'd2, "R3 inactive edge summary");
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; mgmt = 1'b0; idx = '0; wr = 1'b0; wdata = '0;
        for (int k = 0; k < NS; k++) src_lvl[k] = idle_lvl(k);
        m_sts = '0; m_en = '0; m_ge = 0; m_di = 0; m_mw = 0; m_sum = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 4; i++) rd_check(2'(i), "R1 reset register");
        oe_check("R1 reset wake_oe");

        // R2 event with enables off still latches, R7 output stays off
        pulse(0);
        rd_check(2'd0, "R2 status latched with enables clear");
        rd_check(2'd2, "R2 summary set");
        oe_check("R7 no wake with global off");

        reg_write(2'd2, 16'h0001);
        oe_check("R6 global on but source enable clear");
        reg_write(2'd1, 16'h0001);
        oe_check("R6 enable set after event asserts wake");
        check("R6 wake asserted", {15'd0, oe}, 16'h0001);
        reg_write(2'd2, 16'h0000);
        oe_check("R7 global off drops wake");
        check("R7 wake low", {15'd0, oe}, 16'h0000);
        reg_write(2'd2, 16'h0001);

        // R4 write-one-to-clear
        reg_write(2'd0, 16'h0000);
        rd_check(2'd0, "R4 write zero keeps status");
        reg_write(2'd0, 16'h0001);
        rd_check(2'd0, "R4 write one clears status");
        oe_check("R4 wake drops after clear");
        reg_write(2'd2, 16'h8001);
        rd_check(2'd2, "R4 summary cleared");

        // R3 polarity: falling fixed source, rising GP0, falling GP7
        inactive_edge(0);
        inactive_edge(5);
        inactive_edge(NS-1);
        pulse(5);
        rd_check(2'd0, "R3 rising GP edge sets status");
        pulse(NS-1);
        rd_check(2'd0, "R3 falling GP edge sets status");
        reg_write(2'd0, 16'hFFFF);
        reg_write(2'd1, 16'h0000);

        // R8 management path gating
        @(negedge clk); mgmt = 1'b1; settle();
        oe_check("R8 mgmt with neither gate");
        reg_write(2'd2, 16'h0003);
        oe_check("R8 mgmt with device gate only");
        reg_write(2'd2, 16'h0005);
        oe_check("R8 mgmt with wake gate only");
        reg_write(2'd2, 16'h0007);
        oe_check("R8 mgmt with both gates");
        check("R8 wake asserted", {15'd0, oe}, 16'h0001);
        reg_write(2'd2, 16'h0006);
        oe_check("R7 mgmt blocked by global off");
        rd_check(2'd2, "R9 control readback");
        @(negedge clk); mgmt = 1'b0; settle();
        reg_write(2'd2, 16'h8001);

        // R5 set and clear in the same cycle
        @(negedge clk);
        src_lvl[3] = ~idle_lvl(3);
        @(negedge clk);
        @(negedge clk);
        idx = 2'd0; wdata = 16'h0008; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        m_sts[3] = 1'b1; m_sum = 1'b1;
        repeat (3) @(negedge clk);
        src_lvl[3] = idle_lvl(3);
        repeat (4) @(negedge clk);
        rd_check(2'd0, "R5 set wins over clear");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: pulse(int'($urandom % NS));
                1: reg_write(2'd1, 16'($urandom));
                2: reg_write(2'd0, 16'($urandom));
                3: reg_write(2'd2, 16'($urandom) & 16'h8007);
                default: begin
                    @(negedge clk); mgmt = 1'($urandom); settle();
                end
            endcase
            oe_check("R6 random wake output");
            rd_check(2'd0, "R2 random status");
            if (it % 8 == 0) begin
                rd_check(2'd1, "R9 random enable readback");
                rd_check(2'd2, "R9 random control readback");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule